// File: doc/BRIEF.md
# Indexed Literal-Offset Execution Unit

This block runs three data-memory instructions whose operand sits at a base pointer plus a short unsigned literal taken from the instruction word. It can add the working register to the indexed byte, set a single bit of that byte, or fill the byte with all ones. Every instruction goes through one instruction cycle of four phases, one clock each: decode, read, process, write.

The surrounding core presents a 16-bit instruction together with the 12-bit base pointer, the current working register and the current status flags, and pulses `instr_valid` while `ready` is high. The unit captures these, reads its operand from a single-port byte memory with a combinational read path, and at the end of the write phase returns the updated working register, the updated status flags and an illegal-instruction flag with a one-clock `done` pulse.

States: `PH_IDLE` (waiting, `ready` high), `PH_DECODE` (phase 1), `PH_READ` (phase 2), `PH_PROCESS` (phase 3), `PH_WRITE` (phase 4). Transitions: IDLE to DECODE on `instr_valid`; DECODE to READ, READ to PROCESS, PROCESS to WRITE and WRITE to IDLE, each unconditionally after one clock.

Top module: `idx_exec_unit`

## Requirements
- R1: The effective address is the 12-bit base pointer plus the unsigned literal k in instruction bits 7:0, taken modulo 4096; k may be 0 to 95, and a k of 96 or more makes the instruction illegal.
- R2: The add instruction has bits 15:10 = 001001 and bit 8 = 0; with bit 9 (destination select) = 0 it returns W plus the indexed byte in `w_out` and issues no memory write.
- R3: The add instruction with bit 9 = 1 writes W plus the indexed byte back to the indexed address and returns `w_out` equal to the incoming W.
- R4: After an add, `status_out` holds C in bit 0 (carry out of bit 7), DC in bit 1 (carry out of bit 3), Z in bit 2 (8-bit result zero), OV in bit 3 (signed overflow) and N in bit 4 (result bit 7).
- R5: The bit-set instruction has bits 15:12 = 1000 and bit 8 = 0; it writes the indexed byte with bit b (instruction bits 11:9) set and all other bits as read, and returns `w_out` and `status_out` equal to the incoming values.
- R6: The fill instruction has bits 15:8 = 0x68; it writes 0xFF to the indexed address and returns `w_out` and `status_out` equal to the incoming values.
- R7: Any other instruction word, or any k above 95, sets `illegal` with `done`, performs no memory read or write, and returns `w_out` and `status_out` equal to the incoming values.
- R8: An accepted instruction spends exactly one clock in each of the four phases; `mem_rd_en` is high only in the read phase, `mem_wr_en` only in the write phase, `done` pulses for one clock five clocks after acceptance, and `ready` is high only when idle.
- R9: After reset `ready` is 1 and `done`, `mem_rd_en`, `mem_wr_en`, `illegal`, `w_out` and `status_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Start an instruction (taken when `ready`) |
| instr | input | 16 | Instruction word |
| base_ptr | input | 12 | Base pointer |
| w_in | input | 8 | Incoming working register |
| status_in | input | 5 | Incoming status flags {N,OV,Z,DC,C} |
| ready | output | 1 | Unit idle and able to accept |
| mem_addr | output | 12 | Data memory address |
| mem_rd_en | output | 1 | Data memory read strobe |
| mem_rdata | input | 8 | Data memory read data (combinational) |
| mem_wr_en | output | 1 | Data memory write strobe |
| mem_wdata | output | 8 | Data memory write data |
| done | output | 1 | One-clock completion pulse |
| w_out | output | 8 | Updated working register |
| status_out | output | 5 | Updated status flags |
| illegal | output | 1 | Last instruction was not executable |

## Verification
The assertions assume that `mem_rdata` returns the byte at `mem_addr` within the same clock in which `mem_rd_en` is high, and that `instr_valid` is only meaningful while `ready` is high. The bench memory model answers reads combinationally from its own array and commits writes on the clock edge, and every task raises `instr_valid` for a single clock only after seeing `ready`. The base pointer, W and status inputs are held only during the accepting clock, since the unit captures them there.

// File: rtl/idx_pkg.sv
package idx_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DECODE,
        PH_READ,
        PH_PROCESS,
        PH_WRITE
    } phase_t;

    typedef enum logic [1:0] {
        OP_ADD,
        OP_BSET,
        OP_FILL,
        OP_BAD
    } op_t;

    localparam int STW   = 5;
    localparam int ST_C  = 0;
    localparam int ST_DC = 1;
    localparam int ST_Z  = 2;
    localparam int ST_OV = 3;
    localparam int ST_N  = 4;

endpackage

// File: rtl/idx_decoder.sv
module idx_decoder
    import idx_pkg::*;
#(
    parameter int IW    = 16,
    parameter int AW    = 12,
    parameter int K_MAX = 95
) (
    input  logic [IW-1:0] instr,
    input  logic [AW-1:0] base,
    output op_t           op,
    output logic          dest_mem,
    output logic [2:0]    bit_sel,
    output logic [AW-1:0] ea
);
    localparam int KW = 8;

    logic [KW-1:0] k;
    logic          k_ok;
    logic          is_add;
    logic          is_bset;
    logic          is_fill;

    always_comb begin
        k       = instr[KW-1:0];
        k_ok    = (int'(k) <= K_MAX);
        is_add  = (instr[15:10] == 6'b001001) && !instr[8];
        is_bset = (instr[15:12] == 4'b1000) && !instr[8];
        is_fill = (instr[15:8] == 8'h68);
        ea      = base + AW'(k);
        dest_mem = instr[9];
        bit_sel  = instr[11:9];
        if (!k_ok)        op = OP_BAD;
        else if (is_add)  op = OP_ADD;
        else if (is_bset) op = OP_BSET;
        else if (is_fill) op = OP_FILL;
        else              op = OP_BAD;
    end

endmodule

// File: rtl/idx_alu.sv
module idx_alu
    import idx_pkg::*;
#(
    parameter int DW = 8
) (
    input  op_t            op,
    input  logic [2:0]     bit_sel,
    input  logic [DW-1:0]  w,
    input  logic [DW-1:0]  opnd,
    input  logic [STW-1:0] st_in,
    output logic [DW-1:0]  result,
    output logic [STW-1:0] st_out
);
    localparam int HW = DW / 2;

    logic [DW:0] sum;
    logic [HW:0] half;

    always_comb begin
        sum    = {1'b0, w} + {1'b0, opnd};
        half   = {1'b0, w[HW-1:0]} + {1'b0, opnd[HW-1:0]};
        result = opnd;
        st_out = st_in;
        unique case (op)
            OP_ADD: begin
                result        = sum[DW-1:0];
                st_out[ST_C]  = sum[DW];
                st_out[ST_DC] = half[HW];
                st_out[ST_Z]  = (sum[DW-1:0] == '0);
                st_out[ST_OV] = (w[DW-1] == opnd[DW-1]) && (sum[DW-1] != w[DW-1]);
                st_out[ST_N]  = sum[DW-1];
            end
            OP_BSET: result = opnd | (DW'(1) << bit_sel);
            OP_FILL: result = '1;
            default: result = opnd;
        endcase
    end

endmodule

// File: rtl/idx_exec_unit.sv
module idx_exec_unit
    import idx_pkg::*;
#(
    parameter int IW    = 16,
    parameter int AW    = 12,
    parameter int DW    = 8,
    parameter int K_MAX = 95
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            instr_valid,
    input  logic [IW-1:0]   instr,
    input  logic [AW-1:0]   base_ptr,
    input  logic [DW-1:0]   w_in,
    input  logic [STW-1:0]  status_in,
    output logic            ready,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd_en,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_wr_en,
    output logic [DW-1:0]   mem_wdata,
    output logic            done,
    output logic [DW-1:0]   w_out,
    output logic [STW-1:0]  status_out,
    output logic            illegal
);
    phase_t state_q, state_d;

    logic [IW-1:0]  instr_q;
    logic [AW-1:0]  base_q;
    logic [DW-1:0]  w_q;
    logic [STW-1:0] st_q;

    op_t            op_d, op_q;
    logic           dest_d, dest_q;
    logic [2:0]     bit_d, bit_q;
    logic [AW-1:0]  ea_d, ea_q;

    logic [DW-1:0]  opnd_q;
    logic [DW-1:0]  res_d, res_q;
    logic [STW-1:0] st_res_d, st_res_q;

    idx_decoder #(.IW(IW), .AW(AW), .K_MAX(K_MAX)) u_dec (
        .instr    (instr_q),
        .base     (base_q),
        .op       (op_d),
        .dest_mem (dest_d),
        .bit_sel  (bit_d),
        .ea       (ea_d)
    );

    idx_alu #(.DW(DW)) u_alu (
        .op      (op_q),
        .bit_sel (bit_q),
        .w       (w_q),
        .opnd    (opnd_q),
        .st_in   (st_q),
        .result  (res_d),
        .st_out  (st_res_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:    if (instr_valid) state_d = PH_DECODE;
            PH_DECODE:  state_d = PH_READ;
            PH_READ:    state_d = PH_PROCESS;
            PH_PROCESS: state_d = PH_WRITE;
            PH_WRITE:   state_d = PH_IDLE;
            default:    state_d = PH_IDLE;
        endcase
    end

    // datapath registers, loaded per phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr_q    <= '0;
            base_q     <= '0;
            w_q        <= '0;
            st_q       <= '0;
            op_q       <= OP_BAD;
            dest_q     <= 1'b0;
            bit_q      <= '0;
            ea_q       <= '0;
            opnd_q     <= '0;
            res_q      <= '0;
            st_res_q   <= '0;
            done       <= 1'b0;
            w_out      <= '0;
            status_out <= '0;
            illegal    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                PH_IDLE: begin
                    if (instr_valid) begin
                        instr_q <= instr;
                        base_q  <= base_ptr;
                        w_q     <= w_in;
                        st_q    <= status_in;
                    end
                end
                PH_DECODE: begin
                    op_q   <= op_d;
                    dest_q <= dest_d;
                    bit_q  <= bit_d;
                    ea_q   <= ea_d;
                end
                PH_READ: begin
                    if (op_q != OP_BAD) opnd_q <= mem_rdata;
                end
                PH_PROCESS: begin
                    res_q    <= res_d;
                    st_res_q <= st_res_d;
                end
                PH_WRITE: begin
                    done       <= 1'b1;
                    illegal    <= (op_q == OP_BAD);
                    w_out      <= (op_q == OP_ADD && !dest_q) ? res_q : w_q;
                    status_out <= (op_q == OP_ADD) ? st_res_q : st_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready     = (state_q == PH_IDLE);
        mem_addr  = ea_q;
        mem_wdata = res_q;
        mem_rd_en = (state_q == PH_READ) && (op_q != OP_BAD);
        mem_wr_en = (state_q == PH_WRITE) && (op_q != OP_BAD) &&
                    ((op_q != OP_ADD) || dest_q);
    end

    AST_DECODE_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PH_DECODE |=> state_q == PH_READ); // R8
    AST_READ_BEFORE_PROCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> state_q == PH_PROCESS); // R8
    AST_WRITE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> done); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> $past(!mem_wr_en)); // R7
    AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && op_q == OP_FILL) |-> mem_wdata == '1); // R6
    AST_BSET_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && op_q == OP_BSET) |-> $countones(mem_wdata ^ opnd_q) <= 1); // R5
    AST_BSET_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal && $past(op_q) != OP_ADD) |-> status_out == $past(st_q)); // R5

endmodule

// File: tb/idx_exec_unit_tb.sv
module idx_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [11:0] base_ptr = '0;
    logic [7:0]  w_in = '0;
    logic [4:0]  status_in = '0;
    logic        ready;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata;
    logic        mem_wr_en;
    logic [7:0]  mem_wdata;
    logic        done;
    logic [7:0]  w_out;
    logic [4:0]  status_out;
    logic        illegal;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [7:0] mem [0:4095];
    int rd_cnt, wr_cnt, cycles;
    logic [11:0] rd_addr, wr_addr;

    always #10 clk = ~clk;

    idx_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .base_ptr(base_ptr), .w_in(w_in), .status_in(status_in), .ready(ready),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .done(done),
        .w_out(w_out), .status_out(status_out), .illegal(illegal)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt  <= wr_cnt + 1;
            wr_addr <= mem_addr;
        end
        if (mem_rd_en) begin
            rd_cnt  <= rd_cnt + 1;
            rd_addr <= mem_addr;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] add_flags(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        logic [4:0] f;
        s = {1'b0, a} + {1'b0, b};
        f[0] = s[8];
        f[1] = ((a & 8'h0F) + (b & 8'h0F)) > 8'h0F;
        f[2] = (s[7:0] == 8'h00);
        f[3] = (a[7] == b[7]) && (s[7] != a[7]);
        f[4] = s[7];
        return f;
    endfunction

    task automatic exec(input logic [15:0] ins, input logic [11:0] base,
                        input logic [7:0] w, input logic [4:0] st);
        @(negedge clk);
        chk("R8 ready before issue", ready, 1);
        rd_cnt = 0;
        wr_cnt = 0;
        instr = ins; base_ptr = base; w_in = w; status_in = st;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        instr = '0; base_ptr = '0; w_in = '0; status_in = '0;
        cycles = 1;
        while (!done && cycles < 12) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_reset;
        chk("R9 ready", ready, 1);
        chk("R9 done", done, 0);
        chk("R9 rd_en", mem_rd_en, 0);
        chk("R9 wr_en", mem_wr_en, 0);
        chk("R9 illegal", illegal, 0);
        chk("R9 w_out", w_out, 0);
        chk("R9 status_out", status_out, 0);
    endtask

    task automatic t_add_to_w;
        mem[12'hA2C] = 8'h20;
        exec(16'h242C, 12'hA00, 8'h17, 5'h1F);
        chk("R8 five clocks", cycles, 5);
        chk("R2 w_out", w_out, 8'h37);
        chk("R2 no write", wr_cnt, 0);
        chk("R2 mem kept", mem[12'hA2C], 8'h20);
        chk("R1 read addr", rd_addr, 12'hA2C);
        chk("R8 one read", rd_cnt, 1);
        chk("R4 flags 17+20", status_out, add_flags(8'h17, 8'h20));
        chk("R2 legal", illegal, 0);
        @(negedge clk);
        chk("R8 done pulse", done, 0);
    endtask

    task automatic t_add_to_mem;
        mem[12'h105] = 8'h80;
        exec(16'h2605, 12'h100, 8'h80, 5'h00);
        chk("R3 mem sum", mem[12'h105], 8'h00);
        chk("R3 w kept", w_out, 8'h80);
        chk("R3 one write", wr_cnt, 1);
        chk("R4 C Z OV", status_out, 5'b01101);
    endtask

    task automatic t_add_flags;
        mem[12'h200] = 8'h01;
        exec(16'h2400, 12'h200, 8'h0F, 5'h00);
        chk("R4 DC only", status_out, 5'b00010);
        chk("R2 w 10", w_out, 8'h10);
        mem[12'h201] = 8'h01;
        exec(16'h2401, 12'h200, 8'h7F, 5'h00);
        chk("R4 N OV DC", status_out, 5'b11010);
        chk("R4 model", status_out, add_flags(8'h7F, 8'h01));
    endtask

    task automatic t_bset;
        mem[12'hA0A] = 8'h55;
        exec(16'h8E0A, 12'hA00, 8'h3C, 5'h15);
        chk("R5 bit7", mem[12'hA0A], 8'hD5);
        chk("R5 w kept", w_out, 8'h3C);
        chk("R5 flags kept", status_out, 5'h15);
        chk("R1 write addr", wr_addr, 12'hA0A);
        mem[12'h300] = 8'h01;
        exec(16'h8000, 12'h300, 8'h00, 5'h0A);
        chk("R5 bit0 already set", mem[12'h300], 8'h01);
        chk("R5 flags kept 2", status_out, 5'h0A);
        mem[12'h301] = 8'h00;
        exec(16'h8601, 12'h300, 8'h00, 5'h00);
        chk("R5 bit3", mem[12'h301], 8'h08);
    endtask

    task automatic t_fill_wrap;
        mem[12'h00F] = 8'h12;
        exec(16'h685F, 12'hFB0, 8'hA5, 5'h13);
        chk("R1 k95 wrap", mem[12'h00F], 8'hFF);
        chk("R6 addr", wr_addr, 12'h00F);
        chk("R6 w kept", w_out, 8'hA5);
        chk("R6 flags kept", status_out, 5'h13);
        chk("R1 legal at 95", illegal, 0);
    endtask

    task automatic t_illegal;
        mem[12'h460] = 8'h33;
        exec(16'h6860, 12'h400, 8'h44, 5'h07);
        chk("R1 k96 illegal", illegal, 1);
        chk("R7 no write", wr_cnt, 0);
        chk("R7 no read", rd_cnt, 0);
        chk("R7 mem kept", mem[12'h460], 8'h33);
        chk("R7 w kept", w_out, 8'h44);
        chk("R7 flags kept", status_out, 5'h07);
        exec(16'hFFFF, 12'h000, 8'h11, 5'h01);
        chk("R7 bad opcode", illegal, 1);
        chk("R7 bad no write", wr_cnt, 0);
        exec(16'h2510, 12'h000, 8'h11, 5'h01);
        chk("R7 add bit8", illegal, 1);
        chk("R7 add bit8 w", w_out, 8'h11);
        exec(16'h2410, 12'h000, 8'h11, 5'h01);
        chk("R7 cleared on legal", illegal, 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        rd_cnt = 0; wr_cnt = 0; rd_addr = '0; wr_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add_to_w();
        t_add_to_mem();
        t_add_flags();
        t_bset();
        t_fill_wrap();
        t_illegal();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule